// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock for an I2C controller from a faster system clock. A fixed pre-divider turns the system clock into a slower tick. Two nested programmable counters then stretch each tick train into one SCL half-period. The inner counter holds the sample count and the outer counter holds the step count. Each half-period lasts `PREDIV × sample × step` system clocks, so the bus frequency is the system clock divided by `PREDIV × 2 × sample × step`.

A bit-level engine sits next to this block. It receives the SCL level, a one-cycle pulse in the last cycle of each half-period (one pulse before SCL falls, another before it rises) and a one-cycle sample strobe in the middle of each high half-period. Two timing words configure the block: one for standard/fast timing and one for high-speed timing. A mode input picks between them, and the high-speed word only counts when its two-bit key field is valid.

While the block is disabled it holds SCL high and keeps its counters cleared. A timing word that changes while a half-period is running takes effect at the next boundary, so a configuration write cannot shorten or split a half-period.

Top module: `scl_tg`

## Requirements
- R1: While `enable` is low (and after reset), `scl_out` is 1 and `fall_en`, `rise_en` and `sample_stb` are 0 in the following cycle.
- R2: In normal timing, `norm_cfg[10:8]` holds sample−1 and `norm_cfg[5:0]` holds step−1. Each SCL half-period lasts PREDIV × sample × step clock cycles.
- R3: When `hs_mode` is 1 and `hs_cfg[1:0]` equals 3, the high-speed set is used: `hs_cfg[14:12]` holds sample−1 and `hs_cfg[10:8]` holds step−1 (so step is at most 8). `norm_cfg` has no effect in this case.
- R4: When `hs_cfg[1:0]` is not 3 (for example, an all-zero high-speed word), normal timing from `norm_cfg` is used even if `hs_mode` is 1.
- R5: `fall_en` is high only in the last cycle of a high half-period and `rise_en` only in the last cycle of a low half-period. If `enable` stays high, SCL changes level in the next cycle, and it never changes level at any other time.
- R6: `sample_stb` pulses exactly once per high half-period, PREDIV × sample × floor(step/2) cycles after the half-period starts.
- R7: Timing words are captured only when `enable` rises and at half-period boundaries. A change in the middle of a half-period leaves that half-period's length unchanged and sets the length of the next one.
- R8: Dropping `enable` in the middle of a period forces SCL high in the next cycle. When `enable` rises again, a full-length high half-period starts in the cycle after the first edge that sees `enable` high.
- R9: The limits work: sample 8 with step 64 gives 2048·PREDIV/4·… (PREDIV × 512) cycles, sample 1 with step 1 gives PREDIV cycles, and high-speed sample 8 with step 8 gives PREDIV × 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock; when low, hold SCL high and clear the counters |
| hs_mode | input | 1 | Requests the high-speed timing set |
| norm_cfg | input | 16 | Standard/fast timing word |
| hs_cfg | input | 16 | High-speed timing word with key field in [1:0] |
| scl_out | output | 1 | Serial clock level |
| fall_en | output | 1 | Last cycle of a high half-period |
| rise_en | output | 1 | Last cycle of a low half-period |
| sample_stb | output | 1 | Mid-high-phase sample strobe |

## Verification
The bench targets the following corner cases:
- A configuration change in the middle of a half-period. A design that loads timing words directly would produce a runt half-period.
- A high-speed word with an invalid key. A design that ignores the key would run at the high-speed rate.
- The extreme counts. With sample 1 and step 1, a counter that is off by one would stretch the period. The 64-step limit would overflow a narrow step counter.
- Toggling `enable` in the middle of a period. A design that keeps counting would resume in the middle of a period instead of with a fresh high phase.
- The strobe position with odd step counts. A design that rounds the midpoint up would show its strobe shifted by one step.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
    localparam int CFG_W     = 16;
    localparam int SMP_W     = 3;
    localparam int STP_W     = 6;
    localparam int HS_STP_W  = 3;
    localparam int N_SMP_LSB = 8;
    localparam int N_STP_LSB = 0;
    localparam int H_SMP_LSB = 12;
    localparam int H_STP_LSB = 8;
    localparam int H_KEY_LSB = 0;
    localparam logic [1:0] HS_KEY = 2'b11;

    typedef struct packed {
        logic [SMP_W-1:0] smp;
        logic [STP_W-1:0] stp;
    } lim_t;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import scl_tg_pkg::*;
(
    input  logic             hs_mode,
    input  logic [CFG_W-1:0] norm_cfg,
    input  logic [CFG_W-1:0] hs_cfg,
    output lim_t             lim
);
    logic hs_valid;
    logic unused_cfg_bits;

    assign hs_valid        = hs_mode && (hs_cfg[H_KEY_LSB +: 2] == HS_KEY);
    assign unused_cfg_bits = ^{norm_cfg, hs_cfg};

    always_comb begin
        lim = '0;
        if (hs_valid) begin
            lim.smp = hs_cfg[H_SMP_LSB +: SMP_W];
            lim.stp = STP_W'(hs_cfg[H_STP_LSB +: HS_STP_W]);
        end else begin
            lim.smp = norm_cfg[N_SMP_LSB +: SMP_W];
            lim.stp = norm_cfg[N_STP_LSB +: STP_W];
        end
    end
endmodule

// File: rtl/scl_prediv.sv
module scl_prediv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick,
    output logic first
);
    generate
        if (DIV <= 1) begin : g_bypass
            logic unused_pd;
            assign unused_pd = clk ^ rst_n ^ clr;
            assign tick  = 1'b1;
            assign first = 1'b1;
        end else begin : g_count
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr)               cnt_d = '0;
                else if (cnt_q == LAST) cnt_d = '0;
                else                   cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick  = (cnt_q == LAST);
            assign first = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/scl_nest_cnt.sv
module scl_nest_cnt
    import scl_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  lim_t             lim,
    output logic [SMP_W-1:0] smp_cnt,
    output logic [STP_W-1:0] stp_cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [SMP_W-1:0] smp;
        logic [STP_W-1:0] stp;
    } cnt_t;

    cnt_t c_d, c_q;
    logic smp_last, stp_last;

    assign smp_last = (c_q.smp == lim.smp);
    assign stp_last = (c_q.stp == lim.stp);

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else if (tick) begin
            if (smp_last) begin
                c_d.smp = '0;
                c_d.stp = stp_last ? '0 : c_q.stp + 1'b1;
            end else begin
                c_d.smp = c_q.smp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign smp_cnt = c_q.smp;
    assign stp_cnt = c_q.stp;
    assign wrap    = tick && smp_last && stp_last;
endmodule

// File: rtl/scl_tg.sv
module scl_tg
    import scl_tg_pkg::*;
#(
    parameter int PREDIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hs_mode,
    input  logic [CFG_W-1:0] norm_cfg,
    input  logic [CFG_W-1:0] hs_cfg,
    output logic             scl_out,
    output logic             fall_en,
    output logic             rise_en,
    output logic             sample_stb
);
    typedef struct packed {
        logic run;
        logic scl;
        lim_t lim;
    } state_t;

    state_t st_d, st_q;
    lim_t   live_lim;
    logic   cnt_clr, tick, pre_first, wrap;
    logic [SMP_W-1:0] smp_cnt;
    logic [STP_W-1:0] stp_cnt;
    logic [STP_W:0]   mid_step;

    scl_cfg_decode u_dec (
        .hs_mode  (hs_mode),
        .norm_cfg (norm_cfg),
        .hs_cfg   (hs_cfg),
        .lim      (live_lim)
    );

    assign cnt_clr = !(enable && st_q.run);

    scl_prediv #(.DIV(PREDIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .first (pre_first)
    );

    scl_nest_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .tick    (tick),
        .lim     (st_q.lim),
        .smp_cnt (smp_cnt),
        .stp_cnt (stp_cnt),
        .wrap    (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.run = 1'b0;
            st_d.scl = 1'b1;
            st_d.lim = live_lim;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.scl = 1'b1;
            st_d.lim = live_lim;
        end else if (wrap) begin
            st_d.scl = ~st_q.scl;
            st_d.lim = live_lim;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.scl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mid_step   = ({1'b0, st_q.lim.stp} + 1'b1) >> 1;
    assign scl_out    = st_q.scl;
    assign fall_en    = st_q.run && st_q.scl && wrap;
    assign rise_en    = st_q.run && !st_q.scl && wrap;
    assign sample_stb = st_q.run && st_q.scl && pre_first &&
                        (smp_cnt == '0) && ({1'b0, stp_cnt} == mid_step);
endmodule

// File: rtl/scl_tg_chk.sv
module scl_tg_chk #(
    parameter int PREDIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_out,
    input logic fall_en,
    input logic rise_en,
    input logic sample_stb
);
    int hc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || fall_en || rise_en) hc_q <= 0;
        else                                         hc_q <= hc_q + 1;
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !fall_en && !rise_en && !sample_stb));
    a_r5_fall_next: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_en && enable) |=> !scl_out);
    a_r5_rise_next: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && enable) |=> scl_out);
    a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_out && !rise_en && enable) |=> !scl_out);
    a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && !fall_en) |=> scl_out);
    a_r5_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en |-> scl_out);
    a_r5_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
        rise_en |-> !scl_out);
    a_r5_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_en, rise_en}));
    a_r6_stb_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_out);
    a_r7_min_half: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_en || rise_en) |-> (hc_q >= PREDIV - 1));
endmodule

bind scl_tg scl_tg_chk #(.PREDIV(PREDIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_out    (scl_out),
    .fall_en    (fall_en),
    .rise_en    (rise_en),
    .sample_stb (sample_stb)
);

// File: tb/sim_scl_tg.sv
`timescale 1ns/1ps
module sim_scl_tg;
    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_mode = 1'b0;
    logic [15:0] norm_cfg = 16'h0000;
    logic [15:0] hs_cfg = 16'h0000;
    logic        scl_out, fall_en, rise_en, sample_stb;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    scl_tg #(.PREDIV(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hs_mode(hs_mode),
        .norm_cfg(norm_cfg), .hs_cfg(hs_cfg), .scl_out(scl_out),
        .fall_en(fall_en), .rise_en(rise_en), .sample_stb(sample_stb)
    );

    // Timing selection from the requirements (R2, R3, R4)
    function automatic int sel_smp();
        if (hs_mode && hs_cfg[1:0] == 2'b11) return int'(hs_cfg[14:12]) + 1;
        return int'(norm_cfg[10:8]) + 1;
    endfunction
    function automatic int sel_stp();
        if (hs_mode && hs_cfg[1:0] == 2'b11) return int'(hs_cfg[10:8]) + 1;
        return int'(norm_cfg[5:0]) + 1;
    endfunction

    // Behavioural reference: position inside current half-period
    bit m_run = 0, m_scl = 1;
    int m_pos = 0, m_len = PRE, m_smp = 1, m_stp = 1;

    always @(posedge clk) begin
        if (!rst_n || !enable) begin
            m_run = 0; m_scl = 1; m_pos = 0;
        end else if (!m_run) begin
            m_run = 1; m_scl = 1; m_pos = 0;
            m_smp = sel_smp(); m_stp = sel_stp(); m_len = PRE * m_smp * m_stp;
        end else if (m_pos == m_len - 1) begin
            m_scl = !m_scl; m_pos = 0;
            m_smp = sel_smp(); m_stp = sel_stp(); m_len = PRE * m_smp * m_stp;
        end else begin
            m_pos++;
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("scl_out", int'(scl_out), int'(m_scl));
            check("fall_en", int'(fall_en), int'(m_run && m_scl && m_pos == m_len - 1));
            check("rise_en", int'(rise_en), int'(m_run && !m_scl && m_pos == m_len - 1));
            check("sample_stb", int'(sample_stb),
                  int'(m_run && m_scl && m_pos == PRE * m_smp * (m_stp / 2)));
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(bit en, bit hs, logic [15:0] nc, logic [15:0] hc);
        @(negedge clk); #1;
        enable = en; hs_mode = hs; norm_cfg = nc; hs_cfg = hc;
    endtask

    // Length of the low half-period following the next fall pulse
    task automatic measure_low(int exp);
        int n = 0;
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!fall_en && guard < 20000);
        do begin @(negedge clk); n++; end while (!rise_en && n < 20000);
        check("low half length", n, exp);
    endtask

    task automatic measure_stb(int exp_off);
        int n = 0;
        int cnt = 0;
        int pos = -1;
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!rise_en && guard < 20000);
        do begin
            @(negedge clk); n++;
            if (sample_stb) begin cnt++; if (pos < 0) pos = n; end
        end while (!fall_en && n < 20000);
        check("strobe offset", pos, exp_off + 1);
        check("strobes per high half", cnt, 1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        cur_req = "R1";
        wait_cyc(1);
        check("reset scl", int'(scl_out), 1);
        check("reset pulses", int'(fall_en | rise_en | sample_stb), 0);
        wait_cyc(5);

        cur_req = "R2";
        drive(1, 0, 16'h0102, 16'h0000);          // smp 2, stp 3 -> 24
        measure_low(24);
        cur_req = "R6";
        measure_stb(PRE * 2 * 1);
        cur_req = "R6_odd";
        drive(1, 0, 16'h0204, 16'h0000);          // smp 3, stp 5 -> mid 2
        wait_cyc(150);
        measure_stb(PRE * 3 * 2);

        cur_req = "R7";
        do @(negedge clk); while (!rise_en);
        wait_cyc(3);
        norm_cfg = 16'h0000;                      // change mid high half
        measure_low(PRE);
        wait_cyc(40);

        cur_req = "R3";
        drive(1, 1, 16'h1303, 16'h1203);          // hs smp 2, stp 3 -> 24
        wait_cyc(120);
        measure_low(24);

        cur_req = "R4";
        drive(1, 1, 16'h0203, 16'h0000);          // smp 3, stp 4 -> 48
        wait_cyc(120);
        measure_low(48);
        drive(1, 1, 16'h0203, 16'h1201);          // bad key
        wait_cyc(120);
        measure_low(48);

        cur_req = "R8";
        do @(negedge clk); while (scl_out);
        wait_cyc(5); #1;
        enable = 1'b0;
        wait_cyc(1);
        check("scl forced high", int'(scl_out), 1);
        wait_cyc(2); #1;
        enable = 1'b1;
        measure_low(48);

        cur_req = "R9";
        drive(1, 0, 16'h073F, 16'h0000);          // smp 8, stp 64
        wait_cyc(300);
        measure_low(PRE * 8 * 64);
        drive(1, 0, 16'h0000, 16'h0000);          // smp 1, stp 1
        wait_cyc(2100);
        measure_low(PRE);
        drive(1, 1, 16'h1303, 16'h7703);          // hs smp 8, stp 8
        wait_cyc(20);
        measure_low(PRE * 8 * 8);
        wait_cyc(600);

        cur_req = "R1";
        drive(0, 0, 16'h0102, 16'h0000);
        wait_cyc(2);
        check("idle scl", int'(scl_out), 1);
        wait_cyc(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule